// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block gathers six interrupt request lines from peripheral logic and presents one active-low interrupt request to an 8-bit CPU that runs in vectored mode-2. A rising edge on any request line sets that line's pending flag. A CPU-writable enable mask decides which pending flags may raise the interrupt output and which may compete for service. The sources are a clock/low-battery alarm, a serial byte-received event, a modem carrier-detect change, a barcode trigger, a free-running counter wrap and an expansion-slot request. They are ranked from input 0 (most urgent) to input 5 (least urgent).

When the CPU runs an interrupt acknowledge cycle, the block returns one byte on its data output. The cycle is signalled by the opcode-fetch strobe and the I/O strobe going low together, and it carries two automatic wait states before the final state. The byte returned is the vector of the most urgent enabled pending source. It is always even, because the CPU places it in the low half of a pointer whose high half is its own table-base register, and each table entry is a two-byte routine address. The winner is fixed when the acknowledge starts. Its pending flag is dropped once the acknowledge ends. The output drivers are enabled only during the acknowledge. Bus-request arbitration and the non-maskable input are handled elsewhere and never drive this block's interrupt output.

Top module: `intVectorer`

## Requirements
- R1: After reset, irqN is 1, vecOe is 0, vecData is 00h, the mask is 00h (every source disabled) and no flag is pending.
- R2: A 0-to-1 transition of irqIn[k], sampled on the clock, sets pending flag k. A line held high sets the flag only once, and it does not set the flag again after the flag has been cleared.
- R3: irqN is 0 exactly when some pending flag k has mask bit k equal to 1. An I/O write loads the mask from maskData. The write is iorqN=0, wrN=0 and m1N=1 with addr equal to 40h, and bit k of maskData enables source k.
- R4: Source 0 has the highest priority and source 5 the lowest. The vector of source k is F0h + 2*k, so the vectors are F0h, F2h, F4h, F6h, F8h and FAh.
- R5: The acknowledge condition is m1N=0 and iorqN=0 at a clock edge. vecOe is 1 in the cycle after each clock edge that sees the acknowledge condition, and 0 otherwise. vecData is 00h whenever vecOe is 0.
- R6: The vector is chosen from the enabled pending flags at the first clock edge of an acknowledge, and it stays unchanged for the rest of that acknowledge, even if a higher-priority request arrives meanwhile.
- R7: At the first clock edge after the acknowledge ends, the winner's pending flag is cleared. Other pending flags are kept, and irqN stays 0 if any of them is enabled.
- R8: An acknowledge that finds no enabled pending flag returns FFh and clears no flag.
- R9: A masked source still records its edge in its pending flag, but it is not selected. Setting its mask bit later drives irqN to 0.
- R10: If a new rising edge of the winner's line arrives at the same clock edge that clears its flag, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | 6 | Interrupt request lines, bit 0 most urgent |
| m1N | input | 1 | Opcode-fetch strobe, active low |
| iorqN | input | 1 | I/O request strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| addr | input | 8 | Low byte of the I/O address |
| maskData | input | 6 | Mask value written at the mask port |
| irqN | output | 1 | Interrupt request to the CPU, active low |
| vecData | output | 8 | Vector byte returned during an acknowledge |
| vecOe | output | 1 | Output enable of the vector drivers |

## Verification
The bench targets four cases. The first is a higher-priority edge that lands in the middle of an acknowledge: a design that re-evaluates the winner would change the byte mid-cycle or return the wrong vector. The second is an acknowledge with nothing enabled: it must return FFh and leave every flag intact, where a faulty design would clear a flag or return a real vector. The third is a fresh edge that coincides with the clearing edge: a clear-wins design would lose that request. The fourth covers a masked source, which must keep its flag and must not win. A design that gates the edge detector with the mask would never raise the interrupt once the source is unmasked. A behavioural model runs on every clock, and the six-way simultaneous case confirms the service order.

// File: rtl/intVecPkg.sv
package intVecPkg;

  typedef struct packed {
    logic ackLive;     // acknowledge condition seen at this edge
    logic captureWin;  // first edge of an acknowledge
    logic clearWin;    // first edge after an acknowledge
    logic maskWrite;   // I/O write to the mask port
  } ctrlStrobes_t;

endpackage

// File: rtl/intVecCtrl.sv
module intVecCtrl
  import intVecPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] MASK_PORT = 8'h40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              m1N,
  input  logic              iorqN,
  input  logic              wrN,
  input  logic [ADDR_W-1:0] addr,
  output ctrlStrobes_t      strobes
);

  logic ackNow;
  logic ackPrev;
  logic portHit;

  assign ackNow  = !m1N && !iorqN;
  assign portHit = (addr == MASK_PORT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackPrev <= 1'b0;
    end else begin
      ackPrev <= ackNow;
    end
  end

  always_comb begin
    strobes            = '0;
    strobes.ackLive    = ackNow;
    strobes.captureWin = ackNow && !ackPrev;
    strobes.clearWin   = ackPrev && !ackNow;
    strobes.maskWrite  = !iorqN && !wrN && m1N && portHit;
  end

endmodule

// File: rtl/intVecDatapath.sv
module intVecDatapath
  import intVecPkg::*;
#(
  parameter int NUM_SRC = 6,
  parameter int DATA_W = 8,
  parameter int VEC_BASE = 8'hF0,
  parameter int VEC_STEP = 2,
  parameter int SPURIOUS_VEC = 8'hFF
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic [NUM_SRC-1:0] maskData,
  input  ctrlStrobes_t       strobes,
  output logic               irqN,
  output logic [DATA_W-1:0]  vecData,
  output logic               vecOe,
  output logic [NUM_SRC-1:0] maskQ
);

  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] irqPrev;
  logic [NUM_SRC-1:0] riseHit;
  logic [NUM_SRC-1:0] pendQ;
  logic [NUM_SRC-1:0] liveReq;
  logic [NUM_SRC-1:0] clrHot;
  logic [IDX_W-1:0]   selIdx;
  logic               selValid;
  logic [IDX_W-1:0]   winIdx;
  logic               winValid;
  logic [DATA_W-1:0]  vecReg;
  logic               oeReg;

  function automatic logic [DATA_W-1:0] vecFor(input logic [IDX_W-1:0] idx);
    return DATA_W'(VEC_BASE + VEC_STEP * int'(idx));
  endfunction

  // edge detection of request lines
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqPrev <= '0;
    end else begin
      irqPrev <= irqIn;
    end
  end

  assign riseHit = irqIn & ~irqPrev;

  // winner clear, one-hot
  always_comb begin
    clrHot = '0;
    if (strobes.clearWin && winValid) begin
      clrHot[winIdx] = 1'b1;
    end
  end

  // pending flags, one flop per source; a new edge beats the clear
  for (genvar g = 0; g < NUM_SRC; g++) begin : gPend
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pendQ[g] <= 1'b0;
      end else if (riseHit[g]) begin
        pendQ[g] <= 1'b1;
      end else if (clrHot[g]) begin
        pendQ[g] <= 1'b0;
      end
    end
  end

  // enable mask
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '0;
    end else if (strobes.maskWrite) begin
      maskQ <= maskData;
    end
  end

  assign liveReq = pendQ & maskQ;

  // fixed priority: lowest index wins
  always_comb begin
    selIdx   = '0;
    selValid = 1'b0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (liveReq[i]) begin
        selIdx   = IDX_W'(i);
        selValid = 1'b1;
      end
    end
  end

  // winner freeze and vector register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winIdx   <= '0;
      winValid <= 1'b0;
      vecReg   <= '0;
    end else if (strobes.captureWin) begin
      winIdx   <= selIdx;
      winValid <= selValid;
      vecReg   <= selValid ? vecFor(selIdx) : DATA_W'(SPURIOUS_VEC);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oeReg <= 1'b0;
    end else begin
      oeReg <= strobes.ackLive;
    end
  end

  assign vecOe   = oeReg;
  assign vecData = oeReg ? vecReg : '0;
  assign irqN    = ~|liveReq;

endmodule

// File: rtl/intVectorer.sv
module intVectorer
  import intVecPkg::*;
#(
  parameter int NUM_SRC = 6,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] MASK_PORT = 8'h40,
  parameter int VEC_BASE = 8'hF0,
  parameter int VEC_STEP = 2,
  parameter int SPURIOUS_VEC = 8'hFF
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic               m1N,
  input  logic               iorqN,
  input  logic               wrN,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NUM_SRC-1:0] maskData,
  output logic               irqN,
  output logic [DATA_W-1:0]  vecData,
  output logic               vecOe
);

  ctrlStrobes_t       strobes;
  logic [NUM_SRC-1:0] maskQ;

  intVecCtrl #(
    .ADDR_W(ADDR_W),
    .MASK_PORT(MASK_PORT)
  ) ctrl (
    .clk(clk),
    .rstN(rstN),
    .m1N(m1N),
    .iorqN(iorqN),
    .wrN(wrN),
    .addr(addr),
    .strobes(strobes)
  );

  intVecDatapath #(
    .NUM_SRC(NUM_SRC),
    .DATA_W(DATA_W),
    .VEC_BASE(VEC_BASE),
    .VEC_STEP(VEC_STEP),
    .SPURIOUS_VEC(SPURIOUS_VEC)
  ) dpath (
    .clk(clk),
    .rstN(rstN),
    .irqIn(irqIn),
    .maskData(maskData),
    .strobes(strobes),
    .irqN(irqN),
    .vecData(vecData),
    .vecOe(vecOe),
    .maskQ(maskQ)
  );

endmodule

// File: rtl/intVectorerChecker.sv
module intVectorerChecker #(
  parameter int NUM_SRC = 6,
  parameter int DATA_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               m1N,
  input logic               iorqN,
  input logic               irqN,
  input logic [DATA_W-1:0]  vecData,
  input logic               vecOe,
  input logic [NUM_SRC-1:0] maskQ
);

  // R5: drivers follow the acknowledge condition by one cycle
  a_r5_oe_on_ack: assert property (@(posedge clk) disable iff (!rstN)
    (!m1N && !iorqN) |=> vecOe);

  a_r5_oe_off_idle: assert property (@(posedge clk) disable iff (!rstN)
    (m1N || iorqN) |=> !vecOe);

  // R5: idle data bus value
  a_r5_zero_idle: assert property (@(posedge clk) disable iff (!rstN)
    !vecOe |-> (vecData == '0));

  // R6: vector held steady through an acknowledge
  a_r6_vec_stable: assert property (@(posedge clk) disable iff (!rstN)
    (vecOe && $past(vecOe)) |-> $stable(vecData));

  // R4 / R8: only even vectors or the spurious code appear
  a_r4_vec_even: assert property (@(posedge clk) disable iff (!rstN)
    vecOe |-> (!vecData[0] || (vecData == {DATA_W{1'b1}})));

  // R3: with everything masked the request stays inactive
  a_r3_mask_gates_irq: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == '0) |-> irqN);

endmodule

bind intVectorer intVectorerChecker #(
  .NUM_SRC(NUM_SRC),
  .DATA_W(DATA_W)
) chk (
  .clk(clk),
  .rstN(rstN),
  .m1N(m1N),
  .iorqN(iorqN),
  .irqN(irqN),
  .vecData(vecData),
  .vecOe(vecOe),
  .maskQ(maskQ)
);

// File: tb/intVectorer_test.sv
module intVectorer_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] irqIn = '0;
  logic       m1N = 1'b1;
  logic       iorqN = 1'b1;
  logic       wrN = 1'b1;
  logic [7:0] addr = '0;
  logic [5:0] maskData = '0;
  logic       irqN;
  logic [7:0] vecData;
  logic       vecOe;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  intVectorer uut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .m1N(m1N), .iorqN(iorqN),
    .wrN(wrN), .addr(addr), .maskData(maskData),
    .irqN(irqN), .vecData(vecData), .vecOe(vecOe)
  );

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, actual, expected, $time);
    end
  endtask

  // behavioural reference model
  bit [5:0] mPrev, mPend, mMask;
  bit       mAckPrev, mOe, mWinValid;
  int       mWin;
  int       mVec;

  always @(posedge clk) begin
    if (!rstN) begin
      mPrev = 0; mPend = 0; mMask = 0; mAckPrev = 0; mOe = 0;
      mWinValid = 0; mWin = 0; mVec = 0;
    end else begin
      bit ack;
      bit [5:0] rise, clr;
      ack  = !m1N && !iorqN;
      rise = irqIn & ~mPrev;
      clr  = 0;
      if (mAckPrev && !ack && mWinValid) clr[mWin] = 1;
      if (ack && !mAckPrev) begin
        mWinValid = 0;
        for (int k = 5; k >= 0; k--)
          if (mPend[k] && mMask[k]) begin mWinValid = 1; mWin = k; end
        mVec = mWinValid ? (8'hF0 + 2 * mWin) : 8'hFF;
      end
      if (!iorqN && !wrN && m1N && addr == 8'h40) mMask = maskData;
      mPend    = (mPend & ~clr) | rise;
      mOe      = ack;
      mAckPrev = ack;
      mPrev    = irqIn;
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      check("R3 irqN model", irqN, !(|(mPend & mMask)));
      check("R5 vecOe model", vecOe, mOe);
      check("R4 vecData model", vecData, mOe ? mVec : 0);
    end
  end

  task automatic pulse(input logic [5:0] b);
    @(negedge clk) irqIn = irqIn | b;
    @(negedge clk) irqIn = irqIn & ~b;
  endtask

  task automatic wrMask(input logic [5:0] v);
    @(negedge clk) begin addr = 8'h40; maskData = v; iorqN = 0; wrN = 0; end
    @(negedge clk) begin iorqN = 1; wrN = 1; addr = 0; end
  endtask

  task automatic ackCycle(output logic [7:0] got, input logic [5:0] midInj,
                          input logic [5:0] endInj);
    @(negedge clk) m1N = 0;
    @(negedge clk) iorqN = 0;
    @(negedge clk) irqIn = irqIn | midInj;
    @(negedge clk) irqIn = irqIn & ~midInj;
    @(negedge clk) begin
      got = vecData; m1N = 1; iorqN = 1; irqIn = irqIn | endInj;
    end
    @(negedge clk) irqIn = irqIn & ~endInj;
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    check("R1 irqN reset", irqN, 1);
    check("R1 vecOe reset", vecOe, 0);
    check("R1 vecData reset", vecData, 0);
    rstN = 1;
    pulse(6'b001000);
    check("R1 mask zero keeps irqN high", irqN, 1);
    wrMask(6'h3F);
    @(negedge clk);
    check("R3 enabled pending drives irqN", irqN, 0);
    ackCycle(v, 0, 0);
    check("R4 vector of source 3", v, 8'hF6);
    check("R7 irqN released", irqN, 1);

    pulse(6'b100010);
    ackCycle(v, 0, 0);
    check("R4 source 1 beats 5", v, 8'hF2);
    check("R7 other pending keeps irqN", irqN, 0);
    ackCycle(v, 0, 0);
    check("R4 vector of source 5", v, 8'hFA);
    check("R7 last cleared", irqN, 1);

    pulse(6'b010000);
    ackCycle(v, 6'b000001, 0);
    check("R6 frozen winner", v, 8'hF8);
    ackCycle(v, 0, 0);
    check("R6 late source served next", v, 8'hF0);

    ackCycle(v, 0, 0);
    check("R8 spurious vector", v, 8'hFF);
    check("R8 nothing pending", irqN, 1);

    wrMask(6'h3E);
    pulse(6'b000101);
    ackCycle(v, 0, 0);
    check("R9 masked source skipped", v, 8'hF4);
    check("R9 masked pending hidden", irqN, 1);
    wrMask(6'h3F);
    @(negedge clk);
    check("R9 unmask raises irqN", irqN, 0);
    ackCycle(v, 0, 0);
    check("R9 unmasked source served", v, 8'hF0);

    @(negedge clk) irqIn = 6'b000100;
    @(negedge clk);
    ackCycle(v, 0, 0);
    check("R2 held line served once", v, 8'hF4);
    repeat (3) @(negedge clk);
    check("R2 held line no re-trigger", irqN, 1);
    @(negedge clk) irqIn = 0;

    pulse(6'b001000);
    ackCycle(v, 0, 6'b001000);
    check("R10 coincident edge vector", v, 8'hF6);
    check("R10 coincident edge kept", irqN, 0);
    ackCycle(v, 0, 0);
    check("R10 source served again", v, 8'hF6);

    pulse(6'h3F);
    for (int k = 0; k < 6; k++) begin
      ackCycle(v, 0, 0);
      check("R4 six-way order", v, 8'hF0 + 2 * k);
    end
    check("R7 all cleared", irqN, 1);

    repeat (2) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule